// File: doc/BRIEF.md
# Rotate-right execution unit

This unit executes the five rotate-right operations of a 32-bit instruction stream. It decodes the instruction word and works out the rotate amount. The amount comes either from the 5-bit immediate field or from the low bits of a second register value. It then rotates either the low 32-bit word or the whole 64-bit source to the right. The 64-bit result goes out together with a write enable and the destination register index. The register file and pipeline control sit outside the unit: the surrounding pipeline supplies the two operand values and uses the write enable and destination index.

A doubleword form adds 32 to its immediate, so rotations of 32 to 63 are reachable with a 5-bit field. Word results are sign-extended from bit 31. Any encoding the unit does not recognise gives no write and raises an illegal-instruction flag.

The datapath is combinational. A parameter adds one output register stage, and that stage is on by default.

Top module: `rot_unit`

## Requirements
- R1: A word rotate by immediate is encoded as bits 31:26 = 000000, bits 25:21 = 00001 and bits 5:0 = 000010. It rotates `src_i[31:0]` right by bits 10:6 and writes the 32-bit result sign-extended from its bit 31. Bits 63:32 of `src_i` have no effect.
- R2: A doubleword rotate by immediate is encoded with the same fixed fields as R1 and bits 5:0 = 111010. It rotates all 64 bits of `src_i` right by bits 10:6.
- R3: A doubleword rotate by immediate plus 32 uses the same fixed fields as R1 and bits 5:0 = 111110. It rotates all 64 bits right by (bits 10:6) + 32.
- R4: A word variable rotate is encoded as bits 31:26 = 000000, bits 10:6 = 00001 and bits 5:0 = 000110. It rotates `src_i[31:0]` right by `amt_i[4:0]` and writes the result sign-extended. `amt_i` bits above 4 have no effect.
- R5: A doubleword variable rotate is encoded with the same fixed fields as R4 and bits 5:0 = 010110. It rotates 64 bits right by `amt_i[5:0]`. `amt_i` bits above 5 have no effect.
- R6: A rotate amount of zero returns the source unchanged for doubleword forms, and the sign-extended low word for word forms.
- R7: For a recognised operation with `valid_i` high, `wr_en_o` is 1 and `dst_o` equals instruction bits 15:11.
- R8: With `valid_i` high and an unrecognised encoding, `illegal_o` is 1, `wr_en_o` is 0 and `res_o` is 0. Unrecognised encodings include a wrong fixed field in an otherwise known form. `wr_en_o` and `illegal_o` are never both 1.
- R9: With `valid_i` low, `wr_en_o`, `illegal_o`, `res_o` and `dst_o` are all 0.
- R10: With `REG_OUT` = 1, every output reflects the inputs sampled at the previous rising clock edge. Reset (`rst_n` low, asynchronous) clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction and operands are present this cycle |
| instr_i | input | 32 | Instruction word |
| src_i | input | XLEN (64) | Value to rotate |
| amt_i | input | XLEN (64) | Amount register value for variable forms |
| res_o | output | XLEN (64) | Rotated result, 0 when not writing |
| wr_en_o | output | 1 | Destination write enable |
| dst_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Unrecognised encoding flag |

## Verification
With the default output register, every result, write enable, destination index and illegal flag is due at the first rising edge after the inputs are applied. Nothing else lies in that path, so there is exactly one cycle of latency. The driver applies one operation per falling edge and queues the value it expects. The monitor pops one entry two nanoseconds after each rising edge, which is one edge after the matching stimulus. Every output is therefore compared in the cycle it is due and away from the edge. The rotation models in the bench move bits one index at a time and share nothing with the log-stage rotator.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ROR_W,
        OP_ROR_D,
        OP_ROR_D32,
        OP_RORV_W,
        OP_RORV_D
    } rot_op_e;

    localparam logic [5:0] FN_ROR_W   = 6'b000010;
    localparam logic [5:0] FN_ROR_D   = 6'b111010;
    localparam logic [5:0] FN_ROR_D32 = 6'b111110;
    localparam logic [5:0] FN_RORV_W  = 6'b000110;
    localparam logic [5:0] FN_RORV_D  = 6'b010110;
    localparam logic [4:0] FIX_ONE    = 5'b00001;

endpackage

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
#(
    parameter int XLEN  = 64,
    localparam int AMT_W = $clog2(XLEN)
) (
    input  logic             valid_i,
    input  logic [31:0]      instr_i,
    input  logic [AMT_W-1:0] amt_reg_i,
    output rot_op_e          op_o,
    output logic [AMT_W-1:0] amt_o
);

    logic [4:0] imm_sh;
    logic [4:0] rs_fld;
    assign imm_sh = instr_i[10:6];
    assign rs_fld = instr_i[25:21];

    always_comb begin
        op_o  = OP_NONE;
        amt_o = '0;
        if (valid_i && instr_i[31:26] == 6'b000000) begin
            unique case (instr_i[5:0])
                FN_ROR_W: if (rs_fld == FIX_ONE) begin
                    op_o  = OP_ROR_W;
                    amt_o = AMT_W'(imm_sh);
                end
                FN_ROR_D: if (rs_fld == FIX_ONE) begin
                    op_o  = OP_ROR_D;
                    amt_o = AMT_W'(imm_sh);
                end
                FN_ROR_D32: if (rs_fld == FIX_ONE) begin
                    op_o  = OP_ROR_D32;
                    amt_o = AMT_W'(imm_sh) + AMT_W'(XLEN / 2);
                end
                FN_RORV_W: if (imm_sh == FIX_ONE) begin
                    op_o  = OP_RORV_W;
                    amt_o = AMT_W'(amt_reg_i[AMT_W-2:0]);
                end
                FN_RORV_D: if (imm_sh == FIX_ONE) begin
                    op_o  = OP_RORV_D;
                    amt_o = amt_reg_i;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
    parameter int W  = 64,
    localparam int LG = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [LG-1:0] amt_i,
    output logic [W-1:0]  data_o
);

    logic [W-1:0] stg [0:LG];
    assign stg[0] = data_i;

    for (genvar k = 0; k < LG; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt_i[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
    end

    assign data_o = stg[LG];

endmodule

// File: rtl/rot_unit.sv
module rot_unit
    import rot_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int AMT_W  = $clog2(XLEN),
    localparam int HALF   = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] amt_i,
    output logic [XLEN-1:0] res_o,
    output logic            wr_en_o,
    output logic [4:0]      dst_o,
    output logic            illegal_o
);

    rot_op_e          op;
    logic [AMT_W-1:0] amt;
    logic [XLEN-1:0]  dbl_rot;
    logic [HALF-1:0]  word_rot;

    logic [XLEN-1:0]  res_c;
    logic             wr_c;
    logic             ill_c;
    logic [4:0]       dst_c;

    logic unused_bits;
    assign unused_bits = ^{amt_i[XLEN-1:AMT_W], instr_i[20:16]};

    rot_decode #(.XLEN(XLEN)) u_dec (
        .valid_i   (valid_i),
        .instr_i   (instr_i),
        .amt_reg_i (amt_i[AMT_W-1:0]),
        .op_o      (op),
        .amt_o     (amt)
    );

    rot_barrel #(.W(XLEN)) u_rot_d (
        .data_i (src_i),
        .amt_i  (amt),
        .data_o (dbl_rot)
    );

    rot_barrel #(.W(HALF)) u_rot_w (
        .data_i (src_i[HALF-1:0]),
        .amt_i  (amt[AMT_W-2:0]),
        .data_o (word_rot)
    );

    always_comb begin
        wr_c  = 1'b0;
        ill_c = 1'b0;
        res_c = '0;
        dst_c = '0;
        unique case (op)
            OP_NONE: ill_c = valid_i;
            OP_ROR_W, OP_RORV_W: begin
                wr_c  = 1'b1;
                res_c = {{HALF{word_rot[HALF-1]}}, word_rot};
                dst_c = instr_i[15:11];
            end
            default: begin
                wr_c  = 1'b1;
                res_c = dbl_rot;
                dst_c = instr_i[15:11];
            end
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_o     <= '0;
                wr_en_o   <= 1'b0;
                dst_o     <= '0;
                illegal_o <= 1'b0;
            end else begin
                res_o     <= res_c;
                wr_en_o   <= wr_c;
                dst_o     <= dst_c;
                illegal_o <= ill_c;
            end
        end
    end else begin : g_comb
        assign res_o     = res_c;
        assign wr_en_o   = wr_c;
        assign dst_o     = dst_c;
        assign illegal_o = ill_c;
    end

endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk #(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_i,
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] src_i,
    input logic [XLEN-1:0] res_o,
    input logic            wr_en_o,
    input logic [4:0]      dst_o,
    input logic            illegal_o
);

    localparam int HALF = XLEN / 2;

    logic imm_hdr;
    logic known;
    assign imm_hdr = instr_i[31:21] == 11'b00000000001;
    assign known   = imm_hdr && (instr_i[5:0] == 6'b000010 || instr_i[5:0] == 6'b111010
                                 || instr_i[5:0] == 6'b111110);

    // R8: write and illegal flags are exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && illegal_o));

    if (REG_OUT) begin : g_seq
        a_r1_word_signext: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && imm_hdr && instr_i[5:0] == 6'b000010)
            |=> (wr_en_o && res_o[XLEN-1:HALF] == {HALF{res_o[HALF-1]}}));

        a_r6_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && imm_hdr && instr_i[5:0] == 6'b111010 && instr_i[10:6] == 5'd0)
            |=> (res_o == $past(src_i)));

        a_r7_dest_index: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && known) |=> (wr_en_o && dst_o == $past(instr_i[15:11])));

        a_r8_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && instr_i[31:26] != 6'b000000)
            |=> (illegal_o && !wr_en_o && res_o == '0));

        a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i |=> (!wr_en_o && !illegal_o && res_o == '0 && dst_o == '0));
    end

endmodule

bind rot_unit rot_unit_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .src_i     (src_i),
    .res_o     (res_o),
    .wr_en_o   (wr_en_o),
    .dst_o     (dst_o),
    .illegal_o (illegal_o)
);

// File: tb/test_rot_unit.sv
module test_rot_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] amt_i = '0;
    logic [63:0] res_o;
    logic        wr_en_o;
    logic [4:0]  dst_o;
    logic        illegal_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        wr;
        logic        ill;
        logic [4:0]  dst;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    rot_unit i_rot_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .instr_i   (instr_i),
        .src_i     (src_i),
        .amt_i     (amt_i),
        .res_o     (res_o),
        .wr_en_o   (wr_en_o),
        .dst_o     (dst_o),
        .illegal_o (illegal_o)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] b, input logic [4:0] d,
                                       input logic [4:0] s, input logic [5:0] fn);
        return {op, a, b, d, s, fn};
    endfunction

    function automatic logic [63:0] rot64(input logic [63:0] x, input int s);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = x[(i + s) % 64];
        return r;
    endfunction

    function automatic logic [63:0] rot32s(input logic [63:0] x, input int s);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = x[(i + s) % 32];
        return {{32{r[31]}}, r};
    endfunction

    task automatic drive(input logic v, input logic [31:0] ins, input logic [63:0] s,
                         input logic [63:0] a, input exp_t e);
        @(negedge clk);
        valid_i = v;
        instr_i = ins;
        src_i   = s;
        amt_i   = a;
        sb.push_back(e);
    endtask

    task automatic op_ok(input string tag, input logic [31:0] ins, input logic [63:0] s,
                         input logic [63:0] a, input logic [63:0] res);
        exp_t e;
        e.res = res; e.wr = 1'b1; e.ill = 1'b0; e.dst = ins[15:11]; e.tag = tag;
        drive(1'b1, ins, s, a, e);
    endtask

    task automatic op_bad(input string tag, input logic [31:0] ins);
        exp_t e;
        e.res = '0; e.wr = 1'b0; e.ill = 1'b1; e.dst = '0; e.tag = tag;
        drive(1'b1, ins, 64'hDEAD_BEEF_0123_4567, 64'h3, e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        e.res = '0; e.wr = 1'b0; e.ill = 1'b0; e.dst = '0; e.tag = tag;
        drive(1'b0, mk(6'd0, 5'd1, 5'd2, 5'd9, 5'd3, 6'b111010), 64'hFFFF, 64'h1, e);
    endtask

    // Monitor: one expected item per rising edge, sampled 2 ns later
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (res_o !== e.res || wr_en_o !== e.wr || illegal_o !== e.ill
                    || dst_o !== e.dst) begin
                    n_fail++;
                    $display("FAIL %s: res=%h wr=%b ill=%b dst=%0d expected res=%h wr=%b ill=%b dst=%0d",
                             e.tag, res_o, wr_en_o, illegal_o, dst_o, e.res, e.wr, e.ill, e.dst);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] s1;
        s1 = 64'h1234_5678_8000_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        n_chk++;    // R10: reset state
        if (res_o !== '0 || wr_en_o !== 1'b0 || illegal_o !== 1'b0 || dst_o !== '0) begin
            n_fail++;
            $display("FAIL R10 reset: res=%h wr=%b ill=%b dst=%0d expected all zero",
                     res_o, wr_en_o, illegal_o, dst_o);
        end

        // R1 word immediate, upper source bits ignored
        op_ok("R1", mk(6'd0, 5'd1, 5'd4, 5'd7, 5'd1, 6'b000010), s1, 64'h0, rot32s(s1, 1));
        op_ok("R1", mk(6'd0, 5'd1, 5'd4, 5'd8, 5'd31, 6'b000010), s1, 64'h0, rot32s(s1, 31));
        op_ok("R1", mk(6'd0, 5'd1, 5'd4, 5'd9, 5'd16, 6'b000010),
              64'hFFFF_FFFF_0000_8000, 64'h0, 64'hFFFF_FFFF_8000_0000);
        op_ok("R1", mk(6'd0, 5'd1, 5'd4, 5'd10, 5'd4, 6'b000010),
              64'hFFFF_FFFF_0000_0010, 64'h0, 64'h0000_0000_0000_0001);
        // R2 doubleword immediate
        op_ok("R2", mk(6'd0, 5'd1, 5'd4, 5'd11, 5'd4, 6'b111010),
              64'h0123_4567_89AB_CDEF, 64'h0, 64'hF012_3456_789A_BCDE);
        op_ok("R2", mk(6'd0, 5'd1, 5'd4, 5'd12, 5'd31, 6'b111010), s1, 64'h0, rot64(s1, 31));
        // R3 doubleword immediate plus 32
        op_ok("R3", mk(6'd0, 5'd1, 5'd4, 5'd13, 5'd0, 6'b111110),
              64'h0123_4567_89AB_CDEF, 64'h0, 64'h89AB_CDEF_0123_4567);
        op_ok("R3", mk(6'd0, 5'd1, 5'd4, 5'd14, 5'd31, 6'b111110), s1, 64'h0, rot64(s1, 63));
        // R4 word variable, amount masked to 5 bits
        op_ok("R4", mk(6'd0, 5'd6, 5'd4, 5'd15, 5'd1, 6'b000110), s1,
              64'hFFFF_FFFF_FFFF_FFE3, rot32s(s1, 3));
        op_ok("R4", mk(6'd0, 5'd6, 5'd4, 5'd16, 5'd1, 6'b000110), s1,
              64'h0000_0000_0000_0020, rot32s(s1, 0));
        // R5 doubleword variable, amount masked to 6 bits
        op_ok("R5", mk(6'd0, 5'd6, 5'd4, 5'd17, 5'd1, 6'b010110), s1,
              64'h0000_0000_0000_007F, rot64(s1, 63));
        op_ok("R5", mk(6'd0, 5'd6, 5'd4, 5'd18, 5'd1, 6'b010110), s1,
              64'hFFFF_FFFF_FFFF_FF65, rot64(s1, 37));
        // R6 zero amounts
        op_ok("R6", mk(6'd0, 5'd1, 5'd4, 5'd19, 5'd0, 6'b111010), s1, 64'h0, s1);
        op_ok("R6", mk(6'd0, 5'd1, 5'd4, 5'd20, 5'd0, 6'b000010), s1, 64'h0,
              64'hFFFF_FFFF_8000_0001);
        op_ok("R6", mk(6'd0, 5'd6, 5'd4, 5'd21, 5'd1, 6'b010110), s1, 64'h40, s1);
        // R7 destination index corners
        op_ok("R7", mk(6'd0, 5'd1, 5'd4, 5'd31, 5'd8, 6'b111010), s1, 64'h0, rot64(s1, 8));
        op_ok("R7", mk(6'd0, 5'd1, 5'd4, 5'd0, 5'd8, 6'b111010), s1, 64'h0, rot64(s1, 8));
        // R8 unrecognised encodings
        op_bad("R8", mk(6'd0, 5'd0, 5'd4, 5'd7, 5'd1, 6'b000010));
        op_bad("R8", mk(6'd0, 5'd6, 5'd4, 5'd7, 5'd2, 6'b000110));
        op_bad("R8", mk(6'd1, 5'd1, 5'd4, 5'd7, 5'd1, 6'b111010));
        op_bad("R8", mk(6'd0, 5'd1, 5'd4, 5'd7, 5'd1, 6'b111111));
        op_bad("R8", mk(6'd0, 5'd3, 5'd4, 5'd7, 5'd1, 6'b111110));
        // R9 idle cycles, then back-to-back recovery (R10 latency)
        idle("R9");
        op_ok("R10", mk(6'd0, 5'd1, 5'd4, 5'd5, 5'd2, 6'b111010),
              64'h0000_0000_0000_0003, 64'h0, 64'hC000_0000_0000_0000);
        idle("R9");
        idle("R9");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule